// File: doc/BRIEF.md
# Key-Guarded Watchdog Reset Timer

This block is a watchdog counter that sits on a simple register bus. Software arms it by setting a match value and an enable word. Once counting is enabled, the counter advances by one every clock. When it reaches the match value, the block latches an expiry flag and can drive a system reset pulse of fixed length.

Every register that changes watchdog behaviour is write-guarded. A write to the match, enable, status or counter-clear register takes effect only if the two writes just before it were a correct key pair: first key `0xBABA` to the first key register, then key `0xEB10` to the second key register. The unlock opens a window for exactly one guarded write. Any bus write that breaks the sequence closes the window.

Reads never need an unlock. The read data path is combinational from the address.

Top module: `kgw_top`

## Requirements
- R1: After reset, the count reads 0, match reads 0xFFFFFFFF, enable reads 0, status reads 0, and `sysResetOut` is low.
- R2: Registers sit at these word addresses: 0 match, 1 enable, 2 count (read-only), 3 status, 4 counter-clear, 5 first key, 6 second key. A guarded write (addresses 0, 1, 3, 4) takes effect only when the two bus writes just before it were 0xBABA to address 5 and then 0xEB10 to address 6. Otherwise it is ignored.
- R3: One unlock admits exactly one guarded write. A second guarded write needs a fresh key pair.
- R4: The unlock is cancelled by any of these: a wrong value in either key, the keys in the wrong order, or any other bus write between the two keys.
- R5: Enable bit 0 set makes the count advance by one each cycle. Enable bit 0 clear holds the count.
- R6: When enable bit 0 is set and the count equals match, status bit 0 is set at the next edge and the count restarts from 0.
- R7: If enable bit 1 is also set at that match, `sysResetOut` is high for exactly RST_CYCLES (default 4) cycles, starting in the cycle after the match.
- R8: An unlocked write to status with bit 0 equal to 0 clears the expiry flag. The same write without an unlock leaves the flag set.
- R9: An unlocked write of any value to counter-clear sets the count to 0. Without an unlock, the count keeps running.
- R10: Reads of every register need no unlock and return data in the same cycle as the address.
- R11: With enable bit 1 set and bit 0 clear, the count does not move, no expiry is flagged and no reset is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe for one cycle |
| busAddr | input | ADDR_W (3) | Word address |
| busWrData | input | DATA_W (32) | Write data |
| busRdData | output | DATA_W (32) | Combinational read data for busAddr |
| sysResetOut | output | 1 | System reset pulse on armed expiry |

## Verification
The results fall due at three different times:
- **Read data** is valid in the same cycle as the address.
- **A guarded write** is visible after the edge that samples it, so the bench sets the address at the following falling edge and reads there.
- **Counting and expiry** follow a fixed schedule. A count enabled at edge P reads k at the falling edge after P+k. With a match of 15, status and the reset pulse appear at the falling edge after P+16, and the pulse is gone after P+20.

Every bus action starts and ends on a falling clock edge. Each check therefore samples a known number of edges after its stimulus, half a period away from the register update.

// File: rtl/kgw_pkg.sv
package kgw_pkg;
  // Word addresses; the key order is behaviour, the rest is layout
  localparam int RegMatch  = 0;
  localparam int RegEnable = 1;
  localparam int RegCount  = 2;
  localparam int RegStatus = 3;
  localparam int RegClear  = 4;
  localparam int RegKeyA   = 5;
  localparam int RegKeyB   = 6;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lockState_t;

  typedef struct packed {
    logic wrMatch;
    logic wrEnable;
    logic wrStatus;
    logic clrCount;
  } kgwStrobe_t;
endpackage

// File: rtl/kgw_ctrl.sv
module kgw_ctrl
  import kgw_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY_A = 'hBABA,
  parameter logic [DATA_W-1:0] KEY_B = 'hEB10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output kgwStrobe_t        strobe
);
  lockState_t lockQ, lockNext;
  logic       isOpen;

  assign isOpen = (lockQ == LK_OPEN);

  always_comb begin
    strobe   = '0;
    lockNext = lockQ;
    if (busWrEn) begin
      // any write ends the current sequence unless it advances it
      lockNext = LK_SHUT;
      if (busAddr == ADDR_W'(RegKeyA)) begin
        if (busWrData == KEY_A) lockNext = LK_HALF;
      end else if (busAddr == ADDR_W'(RegKeyB)) begin
        if (lockQ == LK_HALF && busWrData == KEY_B) lockNext = LK_OPEN;
      end else if (busAddr == ADDR_W'(RegMatch)) begin
        strobe.wrMatch = isOpen;
      end else if (busAddr == ADDR_W'(RegEnable)) begin
        strobe.wrEnable = isOpen;
      end else if (busAddr == ADDR_W'(RegStatus)) begin
        strobe.wrStatus = isOpen;
      end else if (busAddr == ADDR_W'(RegClear)) begin
        strobe.clrCount = isOpen;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockQ <= LK_SHUT;
    else       lockQ <= lockNext;
  end

  // a guarded write must follow a correct second key directly
  assert_key_before_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe) |-> $past(busWrEn && busAddr == ADDR_W'(RegKeyB) && busWrData == KEY_B));

  // unlock serves one write only
  assert_single_use_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe) |=> !(|strobe));

  // a wrong first key can never be followed by a guarded write
  assert_bad_key_closes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(RegKeyA) && busWrData != KEY_A) |=> !(|strobe));
endmodule

// File: rtl/kgw_datapath.sv
module kgw_datapath
  import kgw_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  kgwStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              sysResetOut
);
  localparam int RST_W = $clog2(RST_CYCLES + 1);

  logic [DATA_W-1:0] countQ, matchQ;
  logic [1:0]        enableQ;
  logic              expiredQ;
  logic [RST_W-1:0]  pulseCnt;
  logic              matchHit;

  assign matchHit    = enableQ[0] && (countQ == matchQ);
  assign sysResetOut = (pulseCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchQ  <= '1;
      enableQ <= '0;
    end else begin
      if (strobe.wrMatch)  matchQ  <= wrData;
      if (strobe.wrEnable) enableQ <= wrData[1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         countQ <= '0;
    else if (strobe.clrCount)          countQ <= '0;
    else if (matchHit)                 countQ <= '0;
    else if (enableQ[0])               countQ <= countQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  expiredQ <= 1'b0;
    else if (matchHit)                          expiredQ <= 1'b1;
    else if (strobe.wrStatus && !wrData[0])     expiredQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        pulseCnt <= '0;
    else if (pulseCnt != '0)                          pulseCnt <= pulseCnt - 1'b1;
    else if (matchHit && enableQ[1])                  pulseCnt <= RST_W'(RST_CYCLES);
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(RegMatch))       rdData = matchQ;
    else if (rdAddr == ADDR_W'(RegEnable)) rdData = DATA_W'(enableQ);
    else if (rdAddr == ADDR_W'(RegCount))  rdData = countQ;
    else if (rdAddr == ADDR_W'(RegStatus)) rdData = DATA_W'(expiredQ);
  end

  // checker state: length of the current reset pulse
  logic [RST_W:0] highRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            highRun <= '0;
    else if (sysResetOut) highRun <= highRun + 1'b1;
    else                  highRun <= '0;
  end

  assert_match_guarded_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.wrMatch) |-> $stable(matchQ));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enableQ[0]) && !$past(matchHit) && !$past(strobe.clrCount))
      |-> countQ == $past(countQ) + 1'b1);

  assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(enableQ[0]) && !$past(strobe.clrCount)) |-> $stable(countQ));

  assert_expiry_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(matchHit) |-> rdData == rdData && expiredQ);

  assert_pulse_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysResetOut) |-> $past(enableQ[1] && matchHit));

  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysResetOut) |-> highRun == (RST_W+1)'(RST_CYCLES));

  assert_pulse_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    highRun <= (RST_W+1)'(RST_CYCLES));
endmodule

// File: rtl/kgw_top.sv
module kgw_top
  import kgw_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              sysResetOut
);
  kgwStrobe_t strobe;

  kgw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .strobe(strobe));

  kgw_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .rdAddr(busAddr), .rdData(busRdData), .sysResetOut(sysResetOut));
endmodule

// File: tb/test_kgw_top.sv
`timescale 1ns/1ps
module test_kgw_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        sysResetOut;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  kgw_top i_kgw_top (.clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .sysResetOut(sysResetOut));

  task automatic wr(input int a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = 3'(a); busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic unlock();
    wr(5, 32'hBABA); wr(6, 32'hEB10);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_reg(input string req, input int a, input logic [31:0] exp);
    busAddr = 3'(a); #0.1;
    checks++;
    if (busRdData !== exp) begin
      errors++;
      $display("FAIL %s reg %0d actual %h expected %h", req, a, busRdData, exp);
    end
  endtask

  task automatic expect_rst(input string req, input logic exp);
    checks++;
    if (sysResetOut !== exp) begin
      errors++;
      $display("FAIL %s sysResetOut actual %b expected %b", req, sysResetOut, exp);
    end
  endtask

  task automatic t_reset();
    expect_reg("R1", 2, 32'h0); expect_reg("R1", 0, 32'hFFFFFFFF);
    expect_reg("R1", 1, 32'h0); expect_reg("R1", 3, 32'h0);
    expect_rst("R1", 1'b0);
  endtask

  task automatic t_unlock_write();
    unlock(); wr(0, 32'h55);
    expect_reg("R2 R10", 0, 32'h55);
    wr(0, 32'h66);
    expect_reg("R2 no unlock", 0, 32'h55);
  endtask

  task automatic t_single_use();
    unlock(); wr(0, 32'h10); wr(0, 32'h20);
    expect_reg("R3", 0, 32'h10);
  endtask

  task automatic t_bad_sequences();
    wr(5, 32'hBABB); wr(6, 32'hEB10); wr(0, 32'h30);
    expect_reg("R4 wrong first key", 0, 32'h10);
    wr(5, 32'hBABA); wr(6, 32'hEB11); wr(0, 32'h31);
    expect_reg("R4 wrong second key", 0, 32'h10);
    wr(6, 32'hEB10); wr(5, 32'hBABA); wr(0, 32'h32);
    expect_reg("R4 keys swapped", 0, 32'h10);
    wr(5, 32'hBABA); wr(2, 32'h0); wr(6, 32'hEB10); wr(0, 32'h33);
    expect_reg("R4 write between keys", 0, 32'h10);
  endtask

  task automatic t_counting();
    logic [31:0] held;
    unlock(); wr(0, 32'h1000);
    unlock(); wr(1, 32'h1);
    expect_reg("R5 start", 2, 32'd0);
    idle(5);
    expect_reg("R5 advance", 2, 32'd5);
    unlock(); wr(1, 32'h0);
    busAddr = 3'd2; #0.1; held = busRdData;
    idle(3);
    expect_reg("R5 hold", 2, held);
  endtask

  task automatic t_clear();
    logic [31:0] c;
    unlock(); wr(1, 32'h1);
    idle(4);
    unlock(); wr(4, 32'h0);
    expect_reg("R9 cleared", 2, 32'd0);
    idle(2);
    busAddr = 3'd2; #0.1; c = busRdData;
    wr(4, 32'h0);
    expect_reg("R9 clear ignored", 2, c + 32'd1);
    unlock(); wr(1, 32'h0);
    unlock(); wr(4, 32'h0);
  endtask

  task automatic t_expiry();
    unlock(); wr(0, 32'hF);
    unlock(); wr(1, 32'h3);   // edge P, count 0
    idle(15);
    expect_reg("R6 before match", 3, 32'h0);
    expect_rst("R7 before match", 1'b0);
    idle(1);
    expect_reg("R6 flag set", 3, 32'h1);
    expect_reg("R6 count restarted", 2, 32'h0);
    expect_rst("R7 pulse start", 1'b1);
    idle(3);
    expect_rst("R7 pulse last cycle", 1'b1);
    idle(1);
    expect_rst("R7 pulse ended", 1'b0);
    unlock(); wr(1, 32'h0);
    wr(3, 32'h0);
    expect_reg("R8 clear ignored", 3, 32'h1);
    unlock(); wr(3, 32'h0);
    expect_reg("R8 cleared", 3, 32'h0);
  endtask

  task automatic t_reset_only();
    unlock(); wr(4, 32'h0);
    unlock(); wr(0, 32'h3);
    unlock(); wr(1, 32'h2);
    idle(10);
    expect_reg("R11 count still", 2, 32'h0);
    expect_reg("R11 no flag", 3, 32'h0);
    expect_rst("R11 no reset", 1'b0);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlock_write();
    t_single_use();
    t_bad_sequences();
    t_counting();
    t_clear();
    t_expiry();
    t_reset_only();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog timeout actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule